// File: doc/BRIEF.md
# Sampled Audio Replay Engine

This block plays a buffer of audio samples held in memory. Software programs a 24-bit first address and a 24-bit limit address, one byte at a time, then picks the sample layout and the rate in a mode register. It sets the run bit to start. The engine then reads 16-bit words from memory over a request/acknowledge port. It splits each word into samples and hands them to a DAC-side consumer as one-cycle strobes, one sample per rate tick.

The buffer runs from the first address up to, but not including, the limit address. When the last sample has been emitted, an end event occurs. In loop mode the engine latches the programmed addresses again and keeps playing. Otherwise it clears its run bit and falls silent. The end event pulses either or both interrupt lines, depending on two route bits. The address of the next word to fetch can be read back at any time.

Top module: `snd_replay_top`

## Requirements
- R1: After reset, the control register reads 0, the current address reads 0, and mem_req, smp_valid, irq_a and irq_b are all low.
- R2: The first address bytes (offsets 3, 4, 5 for high, middle, low) and the limit address bytes (offsets 6, 7, 8) read back the values written. The mode register (offset 1) reads back bits 7, 6, 1 and 0.
- R3: Offsets 9, 10 and 11 return the high, middle and low byte of the next fetch address. This address equals the first address right after the run bit is set, and it equals the limit address after a buffer of even length has finished without looping.
- R4: mem_req stays high with a stable mem_addr until mem_ack. Each accepted word advances the address by 2. Words are requested only while the address is below the latched limit.
- R5: With mode bit 6 set, each word is one sample. With it clear, each word gives two samples: the high byte first, then the low byte. Each byte is placed in smp_data[15:8], with smp_data[7:0] zero.
- R6: With mode bit 7 set (mono), smp_chan is 2'b11. With it clear (stereo), smp_chan alternates 2'b01 (left) and 2'b10 (right), starting with left after the run bit is set.
- R7: Consecutive strobes within a buffer are BASE_DIV*8 >> rate cycles apart in mono, and half that in stereo, where rate is mode bits [1:0].
- R8: Without loop mode (control bit 1 clear), control bit 0 reads 0 after the last sample, and no further strobes or requests follow.
- R9: The end event gives a one-cycle pulse on irq_a if route bit 0 of offset 2 is set, and on irq_b if route bit 1 is set. The pulse comes one cycle after the final strobe.
- R10: In loop mode the engine re-latches the first and limit registers at the buffer end and continues. Register writes made during a buffer therefore take effect only at the next pass.
- R11: If the limit is not above the first address, no word is requested, the end event fires at once, and the run bit clears, even in loop mode.
- R12: Writing control bit 0 as 0 stops requests and strobes from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational) |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | 16 | Memory read word |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 16 | Sample value |
| smp_chan | output | 2 | Channel mask: bit 0 left, bit 1 right |
| irq_a | output | 1 | End-of-buffer interrupt, route A |
| irq_b | output | 1 | End-of-buffer interrupt, route B |

## Verification
The addresses are latched on the edge that writes the run bit, so the current-address readback is sampled at the falling edge right after that write. Strobes are registered one cycle after a rate tick. The scoreboard therefore compares gaps between strobes rather than absolute times, using the expected period for each item, and it skips the gap for the first strobe of a pass. The interrupt pulse follows the final strobe by one cycle, so interrupts are counted continuously and compared after a settling wait. The software stop is issued within two cycles of the last expected strobe, before a following pass could produce its first sample.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned RA_W   = 4;

  localparam logic [RA_W-1:0] RA_CTRL    = 4'd0;
  localparam logic [RA_W-1:0] RA_MODE    = 4'd1;
  localparam logic [RA_W-1:0] RA_ROUTE   = 4'd2;
  localparam logic [RA_W-1:0] RA_FIRST_H = 4'd3;
  localparam logic [RA_W-1:0] RA_FIRST_M = 4'd4;
  localparam logic [RA_W-1:0] RA_FIRST_L = 4'd5;
  localparam logic [RA_W-1:0] RA_LIMIT_H = 4'd6;
  localparam logic [RA_W-1:0] RA_LIMIT_M = 4'd7;
  localparam logic [RA_W-1:0] RA_LIMIT_L = 4'd8;
  localparam logic [RA_W-1:0] RA_CUR_H   = 4'd9;
  localparam logic [RA_W-1:0] RA_CUR_M   = 4'd10;
  localparam logic [RA_W-1:0] RA_CUR_L   = 4'd11;

  typedef struct packed {
    logic       mono;
    logic       wide;
    logic [1:0] rate;
  } mode_t;
endpackage

// File: rtl/snd_regs.sv
module snd_regs
  import snd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RA_W-1:0]   addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              end_evt,
  input  logic              stop,
  output logic              on,
  output logic              rpt,
  output mode_t             mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] limit_addr,
  output logic              go,
  output logic              irq_a,
  output logic              irq_b
);
  logic              on_q, on_n, rpt_q, rpt_n;
  mode_t             mode_q, mode_n;
  logic [1:0]        route_q, route_n;
  logic [ADDR_W-1:0] first_q, first_n, limit_q, limit_n;
  logic              irqa_q, irqb_q;

  assign go = we && (addr == RA_CTRL) && wdata[0] && !on_q;

  always_comb begin
    on_n    = stop ? 1'b0 : on_q;
    rpt_n   = rpt_q;
    mode_n  = mode_q;
    route_n = route_q;
    first_n = first_q;
    limit_n = limit_q;
    if (we) begin
      case (addr)
        RA_CTRL:    begin on_n = wdata[0]; rpt_n = wdata[1]; end
        RA_MODE:    mode_n = '{mono: wdata[7], wide: wdata[6], rate: wdata[1:0]};
        RA_ROUTE:   route_n = wdata[1:0];
        RA_FIRST_H: first_n[23:16] = wdata;
        RA_FIRST_M: first_n[15:8]  = wdata;
        RA_FIRST_L: first_n[7:0]   = wdata;
        RA_LIMIT_H: limit_n[23:16] = wdata;
        RA_LIMIT_M: limit_n[15:8]  = wdata;
        RA_LIMIT_L: limit_n[7:0]   = wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL:    rdata = {6'd0, rpt_q, on_q};
      RA_MODE:    rdata = {mode_q.mono, mode_q.wide, 4'd0, mode_q.rate};
      RA_ROUTE:   rdata = {6'd0, route_q};
      RA_FIRST_H: rdata = first_q[23:16];
      RA_FIRST_M: rdata = first_q[15:8];
      RA_FIRST_L: rdata = first_q[7:0];
      RA_LIMIT_H: rdata = limit_q[23:16];
      RA_LIMIT_M: rdata = limit_q[15:8];
      RA_LIMIT_L: rdata = limit_q[7:0];
      RA_CUR_H:   rdata = cur_addr[23:16];
      RA_CUR_M:   rdata = cur_addr[15:8];
      RA_CUR_L:   rdata = cur_addr[7:0];
      default:    rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      rpt_q   <= 1'b0;
      mode_q  <= '0;
      route_q <= '0;
      first_q <= '0;
      limit_q <= '0;
      irqa_q  <= 1'b0;
      irqb_q  <= 1'b0;
    end else begin
      on_q    <= on_n;
      rpt_q   <= rpt_n;
      mode_q  <= mode_n;
      route_q <= route_n;
      first_q <= first_n;
      limit_q <= limit_n;
      irqa_q  <= end_evt && route_q[0];
      irqb_q  <= end_evt && route_q[1];
    end
  end

  assign on         = on_q;
  assign rpt        = rpt_q;
  assign mode       = mode_q;
  assign first_addr = first_q;
  assign limit_addr = limit_q;
  assign irq_a      = irqa_q;
  assign irq_b      = irqb_q;
endmodule

// File: rtl/snd_fetch.sv
module snd_fetch
  import snd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on,
  input  logic              load,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] limit_addr,
  input  logic              want,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              take,
  output logic              fetch_done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] cur_q, cur_n, lim_q, lim_n;
  logic              req_q, req_n;

  assign take       = req_q && mem_ack;
  assign fetch_done = !req_q && (cur_q >= lim_q);

  always_comb begin
    cur_n = cur_q;
    lim_n = lim_q;
    req_n = req_q;
    if (load) begin
      cur_n = first_addr;
      lim_n = limit_addr;
      req_n = 1'b0;
    end else if (!on) begin
      req_n = 1'b0;
    end else if (take) begin
      req_n = 1'b0;
      cur_n = cur_q + STEP;
    end else if (!req_q && want && (cur_q < lim_q)) begin
      req_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      lim_q <= '0;
      req_q <= 1'b0;
    end else begin
      cur_q <= cur_n;
      lim_q <= lim_n;
      req_q <= req_n;
    end
  end

  assign mem_req  = req_q;
  assign cur_addr = cur_q;
endmodule

// File: rtl/snd_unpack.sv
module snd_unpack
  import snd_pkg::*;
#(
  parameter int unsigned BASE_DIV = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on,
  input  mode_t             mode,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  input  logic              fetch_done,
  output logic              full,
  output logic              end_evt,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_data,
  output logic [1:0]        smp_chan
);
  localparam int unsigned       DIV_W = $clog2(BASE_DIV * 8 + 1);
  localparam logic [DIV_W-1:0]  BASE  = DIV_W'(BASE_DIV);

  logic [DIV_W-1:0]  div_q, div_n, per_mono, period;
  logic [WORD_W-1:0] word_q, word_n, data_n, data_q;
  logic [1:0]        cnt_q, cnt_n, chan_n, chan_q;
  logic              right_q, right_n, valid_q;
  logic              tick, emit;

  assign per_mono = BASE << (2'd3 - mode.rate);
  assign period   = mode.mono ? per_mono : (per_mono >> 1);
  assign tick     = div_q >= (period - 1'b1);
  assign emit     = on && tick && (cnt_q != 2'd0);
  assign full     = cnt_q != 2'd0;
  assign end_evt  = on && fetch_done && (cnt_q == 2'd0);

  always_comb begin
    div_n   = div_q;
    word_n  = word_q;
    cnt_n   = cnt_q;
    right_n = right_q;
    data_n  = '0;
    chan_n  = 2'b00;
    if (!on) begin
      div_n   = '0;
      cnt_n   = 2'd0;
      right_n = 1'b0;
    end else begin
      div_n = tick ? '0 : div_q + 1'b1;
      if (take) begin
        word_n = word;
        cnt_n  = mode.wide ? 2'd1 : 2'd2;
      end else if (emit) begin
        cnt_n = cnt_q - 2'd1;
      end
      if (emit) begin
        if (mode.wide)           data_n = word_q;
        else if (cnt_q == 2'd2)  data_n = {word_q[15:8], 8'd0};
        else                     data_n = {word_q[7:0], 8'd0};
        chan_n = mode.mono ? 2'b11 : (right_q ? 2'b10 : 2'b01);
        if (!mode.mono) right_n = !right_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      word_q  <= '0;
      cnt_q   <= 2'd0;
      right_q <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= 2'b00;
    end else begin
      div_q   <= div_n;
      word_q  <= word_n;
      cnt_q   <= cnt_n;
      right_q <= right_n;
      valid_q <= emit;
      data_q  <= data_n;
      chan_q  <= chan_n;
    end
  end

  assign smp_valid = valid_q;
  assign smp_data  = data_q;
  assign smp_chan  = chan_q;
endmodule

// File: rtl/snd_replay_top.sv
module snd_replay_top
  import snd_pkg::*;
#(
  parameter int unsigned BASE_DIV = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_data,
  output logic [1:0]        smp_chan,
  output logic              irq_a,
  output logic              irq_b
);
  logic [1:0]        rst_sync;
  logic              rst_li;
  logic              ctrl_on, ctrl_rpt, go, end_evt, reload, stop, take, full, fetch_done;
  mode_t             mode;
  logic [ADDR_W-1:0] first_addr, limit_addr, cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_li = rst_sync[1];

  assign reload = end_evt && ctrl_rpt && (limit_addr > first_addr);
  assign stop   = end_evt && !reload;

  snd_regs u_regs (
    .clk(clk), .rst_n(rst_li), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cur_addr(cur_addr), .end_evt(end_evt), .stop(stop),
    .on(ctrl_on), .rpt(ctrl_rpt), .mode(mode), .first_addr(first_addr),
    .limit_addr(limit_addr), .go(go), .irq_a(irq_a), .irq_b(irq_b)
  );

  snd_fetch u_fetch (
    .clk(clk), .rst_n(rst_li), .on(ctrl_on), .load(go || reload),
    .first_addr(first_addr), .limit_addr(limit_addr), .want(!full),
    .mem_ack(mem_ack), .mem_req(mem_req), .cur_addr(cur_addr), .take(take),
    .fetch_done(fetch_done)
  );

  snd_unpack #(.BASE_DIV(BASE_DIV)) u_unpack (
    .clk(clk), .rst_n(rst_li), .on(ctrl_on), .mode(mode), .take(take),
    .word(mem_rdata), .fetch_done(fetch_done), .full(full), .end_evt(end_evt),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
  );

  assign mem_addr = cur_addr;
endmodule

// File: rtl/snd_replay_chk.sv
module snd_replay_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [23:0] mem_addr,
  input logic        smp_valid,
  input logic [1:0]  smp_chan,
  input logic        irq_a,
  input logic        irq_b,
  input logic        on
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && on) |=> (mem_req && $stable(mem_addr)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && on) |=> (mem_addr == $past(mem_addr) + 24'd2));

  p_chan_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_chan != 2'b00));

  p_irqa_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |=> !irq_a);

  p_irqb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |=> !irq_b);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (!mem_req && !smp_valid));
endmodule

bind snd_replay_top snd_replay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .smp_valid(smp_valid), .smp_chan(smp_chan),
  .irq_a(irq_a), .irq_b(irq_b), .on(ctrl_on)
);

// File: tb/test_snd_replay_top.sv
module test_snd_replay_top;
  localparam int BASE_DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic [1:0]  smp_chan;
  logic        irq_a, irq_b;

  always #10 clk = ~clk;

  snd_replay_top #(.BASE_DIV(BASE_DIV)) i_snd_replay_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct {
    logic [15:0] d;
    logic [1:0]  ch;
    int          gap;
  } item_t;

  item_t q[$];
  int  checks = 0, errors = 0;
  int  cyc = 0, last_cyc = 0, na = 0, nb = 0, nreq = 0, extra = 0;
  bit  exp_right = 1'b0, first_f = 1'b1, finished = 1'b0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[11:4] + 8'h33};
  endfunction

  // memory model: acknowledges two falling edges after a request appears
  initial begin
    int mwait;
    mwait = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (mwait == 1) begin
          mem_ack = 1'b1;
          mem_rdata = mem_word(mem_addr);
          mwait = 0;
        end else mwait++;
      end else mwait = 0;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (irq_a) na++;
      if (irq_b) nb++;
      if (mem_req) nreq++;
      if (smp_valid) begin
        if (q.size() == 0) begin
          extra++;
          check(1'b0, "R8/R12 strobe with nothing expected", {16'd0, smp_data}, 32'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(smp_data == it.d, "R5 sample value", {16'd0, smp_data}, {16'd0, it.d});
          check(smp_chan == it.ch, "R6 channel mask", {30'd0, smp_chan}, {30'd0, it.ch});
          if (it.gap != 0)
            check((cyc - last_cyc) == it.gap, "R7 strobe spacing", cyc - last_cyc, it.gap);
        end
        last_cyc = cyc;
      end
    end
  end

  task automatic push_one(input logic [15:0] d, input bit mono, input int per);
    item_t it;
    it.d = d;
    it.ch = mono ? 2'b11 : (exp_right ? 2'b10 : 2'b01);
    if (!mono) exp_right = !exp_right;
    it.gap = first_f ? 0 : per;
    first_f = 1'b0;
    q.push_back(it);
  endtask

  task automatic push_pass(input logic [23:0] s, input logic [23:0] e, input bit wide, input bit mono, input int per);
    first_f = 1'b1;
    for (int a = int'(s); a < int'(e); a += 2) begin
      logic [15:0] w;
      w = mem_word(24'(a));
      if (wide) push_one(w, mono, per);
      else begin
        push_one({w[15:8], 8'h00}, mono, per);
        push_one({w[7:0], 8'h00}, mono, per);
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr24(input logic [3:0] base, input logic [23:0] v);
    wr(base, v[23:16]);
    wr(base + 4'd1, v[15:8]);
    wr(base + 4'd2, v[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd24(input logic [3:0] base, output logic [23:0] v);
    logic [7:0] h, m, l;
    rd(base, h); rd(base + 4'd1, m); rd(base + 4'd2, l);
    v = {h, m, l};
  endtask

  task automatic clr_counts();
    na = 0; nb = 0; nreq = 0; extra = 0; exp_right = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, b);  check(b == 8'h00, "R1 control after reset", b, 0);
    rd24(4'd9, v); check(v == 24'd0, "R1 current address after reset", v, 0);
    check(!mem_req && !smp_valid && !irq_a && !irq_b, "R1 outputs idle after reset",
          {mem_req, smp_valid, irq_a, irq_b}, 0);

    // R2 readback, then 16-bit mono at rate 3 with route A
    wr24(4'd3, 24'h012340);
    wr24(4'd6, 24'h012348);
    wr(4'd1, 8'hC3);
    wr(4'd2, 8'h01);
    rd24(4'd3, v); check(v == 24'h012340, "R2 first address readback", v, 24'h012340);
    rd24(4'd6, v); check(v == 24'h012348, "R2 limit address readback", v, 24'h012348);
    rd(4'd1, b);   check(b == 8'hC3, "R2 mode readback", b, 8'hC3);
    clr_counts();
    push_pass(24'h012340, 24'h012348, 1'b1, 1'b1, BASE_DIV);
    wr(4'd0, 8'h01);
    rd24(4'd9, v); check(v == 24'h012340, "R3 current address at start", v, 24'h012340);
    wait (q.size() == 0);
    repeat (40) @(negedge clk);
    rd(4'd0, b);   check(b[0] == 1'b0, "R8 run bit cleared at end", b, 0);
    rd24(4'd9, v); check(v == 24'h012348, "R3 current address at end", v, 24'h012348);
    check(na == 1 && nb == 0, "R9 route A only", {na[15:0], nb[15:0]}, 32'h00010000);
    check(extra == 0, "R8 no strobes after end", extra, 0);

    // R5/R6/R7 8-bit stereo at rate 2 with route B
    wr24(4'd3, 24'h000100);
    wr24(4'd6, 24'h000104);
    wr(4'd1, 8'h02);
    wr(4'd2, 8'h02);
    clr_counts();
    push_pass(24'h000100, 24'h000104, 1'b0, 1'b0, BASE_DIV);
    wr(4'd0, 8'h01);
    wait (q.size() == 0);
    repeat (60) @(negedge clk);
    check(na == 0 && nb == 1, "R9 route B only", {na[15:0], nb[15:0]}, 32'h00000001);
    check(extra == 0, "R8 no strobes after stereo end", extra, 0);

    // R10 loop mode: new addresses written mid-pass take effect at the boundary
    wr24(4'd3, 24'h000200);
    wr24(4'd6, 24'h000208);
    wr(4'd1, 8'h43);
    wr(4'd2, 8'h03);
    clr_counts();
    push_pass(24'h000200, 24'h000208, 1'b1, 1'b0, BASE_DIV / 2);
    push_pass(24'h000300, 24'h000304, 1'b1, 1'b0, BASE_DIV / 2);
    wr(4'd0, 8'h03);
    wr24(4'd3, 24'h000300);
    wr24(4'd6, 24'h000304);
    wait (q.size() == 0);
    @(negedge clk);
    wr(4'd0, 8'h00);          // R12 software stop
    repeat (2) @(negedge clk);
    nreq = 0;
    repeat (300) @(negedge clk);
    check(na == 2 && nb == 2, "R10 two buffer ends in loop mode", {na[15:0], nb[15:0]}, 32'h00020002);
    check(nreq == 0 && !mem_req, "R12 no requests after stop", nreq, 0);
    check(extra == 0, "R12 no strobes after stop", extra, 0);

    // R11 empty buffer in loop mode
    wr24(4'd3, 24'h000400);
    wr24(4'd6, 24'h000400);
    wr(4'd2, 8'h01);
    clr_counts();
    wr(4'd0, 8'h03);
    repeat (20) @(negedge clk);
    check(nreq == 0, "R11 no fetch for empty buffer", nreq, 0);
    rd(4'd0, b); check(b[0] == 1'b0, "R11 run bit cleared", b, 0);
    check(na == 1, "R11 single end event", na, 1);
    check(extra == 0, "R11 no strobes", extra, 0);

    // R7 slowest rate, 8-bit mono
    wr24(4'd3, 24'h000500);
    wr24(4'd6, 24'h000502);
    wr(4'd1, 8'h80);
    clr_counts();
    push_pass(24'h000500, 24'h000502, 1'b0, 1'b1, BASE_DIV * 8);
    wr(4'd0, 8'h01);
    wait (q.size() == 0);
    repeat (20) @(negedge clk);
    rd(4'd0, b); check(b[0] == 1'b0, "R8 run bit cleared at slow rate", b, 0);
    check(na == 1, "R9 route A at slow rate", na, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule